// File: doc/BRIEF.md
# Serial Clock Freeze Controller

This block sits between a clock divider stage and the clock output pins. Twelve divided clocks enter on their own wires. Each one leaves through a gate that can stop it at logic low. Two more clocks, the always-on bank-C clock and the feedback clock, pass through with no gate at all. This means a bad serial load can never stop the clock that keeps a downstream loop locked.

The gates are programmed over a two-wire serial link. The link has a free-running serial clock and a data line that idles high. A frame begins with one low start bit. Twelve enable bits follow, one per serial clock period, each sampled on the rising serial clock edge. When the last bit arrives, the whole word is moved into the active enable register at once. Each enable bit is then carried into the domain of its own divided clock. It reaches the gate only on a falling edge of that clock, so an output is started or stopped only between pulses. No high pulse is ever shortened.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: A frame is a 0 start bit followed by 12 data bits, all sampled on rising `sclk` edges, with data bit 0 sent first. The active enable word changes only on the edge that samples the twelfth data bit.
- R2: Data bit k controls `gated_o[k]`. Bits 0 to 3 belong to bank A outputs 0 to 3, bits 4 to 7 to bank B outputs 0 to 3, bits 8 to 10 to bank C outputs 1 to 3, and bit 11 to the sync clock.
- R3: An enable bit of 1 lets `gated_o[k]` follow `clk_div_i[k]`. A bit of 0 holds `gated_o[k]` at 0. `gated_o[k]` is never high while `clk_div_i[k]` is low.
- R4: A gate opens or closes only while its source clock is low. Every high pulse on `gated_o[k]` is exactly as wide as the source clock's high phase.
- R5: `run_c0_o` and `run_fb_o` follow `run_c0_i` and `run_fb_i` at all times, including during reset and when every enable bit is 0.
- R6: While `rst` is high, the receiver is idle and every gated output is low once its source clock has fallen. A frame cut off by reset has no effect. After reset, all twelve enable bits are 1.
- R7: When no frame is sent, `sdata` held high has no effect on the enable word.
- R8: A start bit sent in the serial period right after the twelfth data bit is accepted, so frames can be sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Free-running serial clock |
| rst | input | 1 | Synchronous active-high reset, sampled in every clock domain |
| sdata | input | 1 | Serial data line, idles high |
| clk_div_i | input | 12 | Ungated divided clocks, index equals enable bit position |
| run_c0_i | input | 1 | Bank C output 0 source clock, never gated |
| run_fb_i | input | 1 | Feedback source clock, never gated |
| gated_o | output | 12 | Gated clocks |
| run_c0_o | output | 1 | Bank C output 0, passed through |
| run_fb_o | output | 1 | Feedback output, passed through |

## Verification
Each divided clock runs at a different period, so a gate that has crossed into the wrong clock domain shows up as a wrong pulse width. Several patterns are loaded: all zeros, single-bit words at both ends, alternating patterns and mixed words. Together they separate a reversed bit order, a shifted frame and a stuck gate from correct behaviour. A long idle-high stretch, a frame cut off by reset and two frames sent with no gap test the start-bit search. A pulse-width monitor on every gated output catches any shortened pulse across all of these changes.

// File: rtl/clk_freeze_pkg.sv
package clk_freeze_pkg;
  localparam int unsigned GATED_OUTPUTS = 12;
  typedef enum logic {RX_IDLE = 1'b0, RX_DATA = 1'b1} rx_state_e;
endpackage

// File: rtl/fz_serial_rx.sv
module fz_serial_rx
  import clk_freeze_pkg::*;
#(
  parameter int unsigned N = GATED_OUTPUTS
) (
  input  logic         sclk,
  input  logic         rst,
  input  logic         sdata,
  output logic [N-1:0] en_word,
  output logic         take
);
  localparam int unsigned CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N-2:0]     shreg_q;

  // the twelfth data bit is on the line during this cycle
  assign take = (state_q == RX_DATA) && (cnt_q == LAST);

  always_ff @(posedge sclk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      en_word <= '1;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (!sdata) begin
            state_q <= RX_DATA;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (take) begin
            en_word <= {sdata, shreg_q};
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            shreg_q[cnt_q] <= sdata;
            cnt_q          <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fz_clk_gate.sv
module fz_clk_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst,
  input  logic en_async,
  output logic gate_q,
  output logic gated
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_src) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
  end

  // gate changes only on the falling edge: the source is low from then on
  always_ff @(negedge clk_src) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= sync_q[SYNC_STAGES-1];
  end

  assign gated = clk_src & gate_q;
endmodule

// File: rtl/clk_freeze_ctrl.sv
module clk_freeze_ctrl
  import clk_freeze_pkg::*;
#(
  parameter int unsigned N_GATED     = GATED_OUTPUTS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               sclk,
  input  logic               rst,
  input  logic               sdata,
  input  logic [N_GATED-1:0] clk_div_i,
  input  logic               run_c0_i,
  input  logic               run_fb_i,
  output logic [N_GATED-1:0] gated_o,
  output logic               run_c0_o,
  output logic               run_fb_o
);
  logic [N_GATED-1:0] en_word;
  logic [N_GATED-1:0] gate_vec;
  logic               take;

  fz_serial_rx #(.N(N_GATED)) u_rx (
    .sclk    (sclk),
    .rst     (rst),
    .sdata   (sdata),
    .en_word (en_word),
    .take    (take)
  );

  for (genvar k = 0; k < N_GATED; k++) begin : g_gate
    fz_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src  (clk_div_i[k]),
      .rst      (rst),
      .en_async (en_word[k]),
      .gate_q   (gate_vec[k]),
      .gated    (gated_o[k])
    );
  end

  assign run_c0_o = run_c0_i;
  assign run_fb_o = run_fb_i;
endmodule

// File: rtl/clk_freeze_ctrl_chk.sv
module clk_freeze_ctrl_chk #(
  parameter int unsigned N = 12
) (
  input logic         sclk,
  input logic         rst,
  input logic         take,
  input logic [N-1:0] en_word,
  input logic [N-1:0] clk_div_i,
  input logic [N-1:0] gate_vec,
  input logic [N-1:0] gated_o
);
  // R1: the enable word moves only on the last data bit
  p_hold_r1: assert property (@(posedge sclk) disable iff (rst)
    !take |=> $stable(en_word))
    else $error("p_hold_r1");

  // R6: reset leaves every enable bit set
  p_reset_on_r6: assert property (@(posedge sclk)
    rst |=> (en_word == {N{1'b1}}))
    else $error("p_reset_on_r6");

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R3: a gated output is never high while its source is low
    p_out_in_r3: assert property (@(posedge sclk)
      gated_o[k] |-> clk_div_i[k])
      else $error("p_out_in_r3 bit %0d", k);

    // R4: gate state changes only while the source clock is low
    always @(gate_vec[k]) begin
      p_gate_low_r4: assert (clk_div_i[k] == 1'b0)
        else $error("p_gate_low_r4 bit %0d", k);
    end
  end
endmodule

bind clk_freeze_ctrl clk_freeze_ctrl_chk #(.N(N_GATED)) u_chk (
  .sclk      (sclk),
  .rst       (rst),
  .take      (take),
  .en_word   (en_word),
  .clk_div_i (clk_div_i),
  .gate_vec  (gate_vec),
  .gated_o   (gated_o)
);

// File: tb/clk_freeze_ctrl_test.sv
`timescale 1ns/1ps
module clk_freeze_ctrl_test;
  localparam int N = 12;

  logic         sclk = 1'b0;
  logic         rst  = 1'b1;
  logic         sdata = 1'b1;
  logic         dclk [N];
  logic [N-1:0] clk_div;
  logic         run_c0 = 1'b0;
  logic         run_fb = 1'b0;
  logic [N-1:0] gated;
  logic         c0_o, fb_o;

  int errors = 0;
  int checks = 0;
  int edge_cnt [N];
  int runt_cnt [N];
  int c0_edges = 0;
  int fb_edges = 0;

  clk_freeze_ctrl uut (
    .sclk      (sclk),
    .rst       (rst),
    .sdata     (sdata),
    .clk_div_i (clk_div),
    .run_c0_i  (run_c0),
    .run_fb_i  (run_fb),
    .gated_o   (gated),
    .run_c0_o  (c0_o),
    .run_fb_o  (fb_o)
  );

  always #5 sclk = ~sclk;
  always #5 run_c0 = ~run_c0;
  always #7 run_fb = ~run_fb;

  always_comb for (int k = 0; k < N; k++) clk_div[k] = dclk[k];

  for (genvar k = 0; k < N; k++) begin : g_src
    time rise_t;
    bit  seen;
    initial begin
      dclk[k] = 1'b0;
      seen = 1'b0;
      edge_cnt[k] = 0;
      runt_cnt[k] = 0;
      forever #(3 + k) dclk[k] = ~dclk[k];
    end
    always @(posedge gated[k]) begin
      edge_cnt[k] = edge_cnt[k] + 1;
      rise_t = $time;
      seen = 1'b1;
    end
    always @(negedge gated[k]) begin
      if (seen && ($time - rise_t != time'(3 + k))) runt_cnt[k] = runt_cnt[k] + 1;
    end
  end

  always @(posedge c0_o) c0_edges = c0_edges + 1;
  always @(posedge fb_o) fb_edges = fb_edges + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // observe all outputs over a window; mask gives the expected enables
  task automatic check_mask(input logic [N-1:0] mask, input string req);
    for (int k = 0; k < N; k++) edge_cnt[k] = 0;
    c0_edges = 0;
    fb_edges = 0;
    #300;
    for (int k = 0; k < N; k++) begin
      if (mask[k])
        check(edge_cnt[k] > 0, req, $sformatf("enabled output %0d pulses", k), edge_cnt[k], 1);
      else
        check(edge_cnt[k] == 0 && gated[k] == 1'b0, req,
              $sformatf("frozen output %0d pulses", k), edge_cnt[k], 0);
    end
    check(c0_edges > 0, "R5", "bank C output 0 pulses", c0_edges, 1);
    check(fb_edges > 0, "R5", "feedback output pulses", fb_edges, 1);
  endtask

  task automatic send_frame(input logic [N-1:0] w, input bit tail_idle);
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < N; i++) @(negedge sclk) sdata = w[i];
    if (tail_idle) @(negedge sclk) sdata = 1'b1;
  endtask

  task automatic load_and_check(input logic [N-1:0] w, input string req);
    send_frame(w, 1'b1);
    #120;
    check_mask(w, req);
  endtask

  task automatic t_reset;
    #60;
    check_mask('0, "R6");
    @(negedge sclk) rst = 1'b0;
    #120;
    check_mask('1, "R6");
  endtask

  task automatic t_patterns;
    load_and_check(12'h000, "R3");
    load_and_check(12'h001, "R1");
    load_and_check(12'h800, "R2");
    load_and_check(12'hAAA, "R2");
    load_and_check(12'h555, "R2");
    load_and_check(12'h70F, "R2");
  endtask

  task automatic t_idle;
    sdata = 1'b1;
    repeat (40) @(negedge sclk);
    check_mask(12'h70F, "R7");
  endtask

  task automatic t_abort;
    @(negedge sclk) sdata = 1'b0;
    repeat (5) @(negedge sclk) sdata = 1'b0;
    rst = 1'b1;
    sdata = 1'b1;
    repeat (3) @(negedge sclk);
    rst = 1'b0;
    #120;
    check_mask('1, "R6");
    load_and_check(12'h0F0, "R6");
  endtask

  task automatic t_back_to_back;
    send_frame(12'h0F0, 1'b0);
    send_frame(12'h30C, 1'b1);
    #120;
    check_mask(12'h30C, "R8");
  endtask

  task automatic t_runts;
    int total = 0;
    for (int k = 0; k < N; k++) total += runt_cnt[k];
    check(total == 0, "R4", "shortened gated pulses", total, 0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_idle();
    t_abort();
    t_back_to_back();
    t_runts();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule